// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block drives a single DRAM bank that has exactly one row buffer. It keeps track of which row is currently latched in that buffer. Each incoming request carries a row address and a column address. The block compares the request with the open row, sorts it into one of three classes, and issues the matching chain of bank commands:

- **Hit**: a column access alone.
- **Empty buffer**: an activate, then a column access.
- **Conflict**: a precharge, then an activate of the new row, then a column access.

How long each step takes is set by a parameter, counted in clock cycles.

Every request also carries a policy bit. With the open-page policy, the row stays latched after the access, so later requests to the same row are cheap. With the close-page policy, a precharge is issued straight after the column access, so the next request finds the buffer empty. When a request finishes, the block raises a one-cycle completion pulse together with the class the request was given.

Requests arrive over a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no command chain is running. The requester must hold its request until it is taken. Whatever is on the request pins while `req_ready` is low is ignored. The command and completion outputs are plain single-cycle pulses with no back-pressure.

Top module: `bank_row_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, no command or completion is issued, and the bank is closed, so the first request is classified empty.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the command chain and any closing precharge are over. Request pins presented while `req_ready` is low have no effect.
- R3: A request whose row equals the open row is a hit (class code 0). The column command appears in the cycle after acceptance, and the completion pulse appears T_CAS cycles after acceptance.
- R4: A request to a closed bank is empty (class code 1). The activate comes in the cycle after acceptance, the column command follows T_ACT cycles later, and completion is due T_ACT+T_CAS cycles after acceptance. An activate is never issued while a row is open.
- R5: A request to a row other than the open one is a conflict (class code 2). The precharge comes in the cycle after acceptance, the activate T_PRE cycles later, the column command T_ACT cycles after that, and completion is due T_PRE+T_ACT+T_CAS cycles after acceptance.
- R6: `cmd_code` is 0 for no command, 1 for precharge, 2 for activate and 3 for column access, and `cmd_valid` is high for exactly one cycle per command. A precharge carries the row being closed. An activate carries the new row. A column access carries the open row and the request's column.
- R7: Under the open-page policy (`req_close_page`=0), the row stays open and `req_ready` returns in the cycle after the completion pulse.
- R8: The policy bit is captured with the request. Under the close-page policy, a precharge of the accessed row is issued in the cycle after completion, `req_ready` returns T_PRE cycles after that precharge, and the next request is classified empty.
- R9: `done_valid` is a single-cycle pulse given exactly once per accepted request, and it carries that request's class on `done_class`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_row | input | ROW_W | Row address of the request |
| req_col | input | COL_W | Column address of the request |
| req_close_page | input | 1 | Policy bit for this request: 1 = close page, 0 = open page |
| cmd_valid | output | 1 | A bank command is issued this cycle |
| cmd_code | output | 2 | Command: 0 none, 1 precharge, 2 activate, 3 column access |
| cmd_row | output | ROW_W | Row carried by the command |
| cmd_col | output | COL_W | Column carried by a column access |
| done_valid | output | 1 | Request completes this cycle |
| done_class | output | 2 | Class of the completing request: 0 hit, 1 empty, 2 conflict |

## Verification
Every output is due at a fixed cycle offset from the acceptance edge. For example, a conflict's activate falls T_PRE+1 cycles after acceptance, and a close-page precharge falls one cycle after the completion pulse. So when the bench accepts a request, its reference model writes out the full cycle-by-cycle list of expected output states. On each falling edge, the bench takes the next entry from that list and compares it with every output port, and it expects the idle state whenever the list is empty. Each acceptance happens at an edge chosen by the bench itself, and requests are held on the pins during busy periods. As a result, a design that takes a request early, or reacts to one while busy, shows up as a shifted or extra command at a definite cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_COL = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_HIT      = 2'd0,
    CLS_EMPTY    = 2'd1,
    CLS_CONFLICT = 2'd2
  } cls_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ACT   = 3'd2,
    ST_COL   = 3'd3,
    ST_CLOSE = 3'd4
  } st_e;
endpackage

// File: rtl/brc_row_tracker.sv
module brc_row_tracker
  import brc_pkg::*;
#(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_fire,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] cmd_row,
  input  logic [ROW_W-1:0] probe_row,
  output logic             open_vld,
  output logic [ROW_W-1:0] open_row,
  output cls_e             probe_cls
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_vld <= 1'b0;
      open_row <= '0;
    end else if (cmd_fire) begin
      if (cmd == CMD_ACT) begin
        open_vld <= 1'b1;
        open_row <= cmd_row;
      end else if (cmd == CMD_PRE) begin
        open_vld <= 1'b0;
      end
    end
  end

  always_comb begin
    if (!open_vld)                  probe_cls = CLS_EMPTY;
    else if (open_row == probe_row) probe_cls = CLS_HIT;
    else                            probe_cls = CLS_CONFLICT;
  end

  // R4
  act_on_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd == CMD_ACT) |-> !open_vld);
  // R5
  pre_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd == CMD_PRE) |-> (open_vld && open_row == cmd_row));
  // R6
  col_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_fire && cmd == CMD_COL) |-> (open_vld && open_row == cmd_row));
endmodule

// File: rtl/brc_step_timer.sv
module brc_step_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] span,
  output logic         first,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (cnt != {W{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign first = (cnt == '0);
  assign last  = (cnt == span - 1'b1);
endmodule

// File: rtl/brc_sequencer.sv
module brc_sequencer
  import brc_pkg::*;
#(
  parameter int T_PRE = 3,
  parameter int T_ACT = 4,
  parameter int T_CAS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  cls_e first_cls,
  input  logic close_req,
  output st_e  state,
  output logic cmd_fire,
  output cmd_e cmd,
  output logic done
);
  localparam int TMAX_A = (T_PRE > T_ACT) ? T_PRE : T_ACT;
  localparam int TMAX   = (TMAX_A > T_CAS) ? TMAX_A : T_CAS;
  localparam int CNT_W  = $clog2(TMAX + 1);

  logic             close_q;
  logic [CNT_W-1:0] span;
  logic             first, last, restart;
  st_e              state_nx;

  always_comb begin
    case (state)
      ST_PRE, ST_CLOSE: span = CNT_W'(T_PRE);
      ST_ACT:           span = CNT_W'(T_ACT);
      ST_COL:           span = CNT_W'(T_CAS);
      default:          span = CNT_W'(1);
    endcase
  end

  assign restart = accept || (state != ST_IDLE && last);

  brc_step_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .span    (span),
    .first   (first),
    .last    (last)
  );

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:
        if (accept) begin
          case (first_cls)
            CLS_HIT:   state_nx = ST_COL;
            CLS_EMPTY: state_nx = ST_ACT;
            default:   state_nx = ST_PRE;
          endcase
        end
      ST_PRE:   if (last) state_nx = ST_ACT;
      ST_ACT:   if (last) state_nx = ST_COL;
      ST_COL:   if (last) state_nx = close_q ? ST_CLOSE : ST_IDLE;
      ST_CLOSE: if (last) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      close_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) close_q <= close_req;
    end
  end

  always_comb begin
    case (state)
      ST_PRE, ST_CLOSE: cmd = CMD_PRE;
      ST_ACT:           cmd = CMD_ACT;
      ST_COL:           cmd = CMD_COL;
      default:          cmd = CMD_NOP;
    endcase
  end

  assign cmd_fire = (state != ST_IDLE) && first;
  assign done     = (state == ST_COL) && last;

  // R8
  close_follows_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && close_q) |=> (cmd_fire && cmd == CMD_PRE));
  // R7
  open_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !close_q) |=> (state == ST_IDLE));
  // R9
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/bank_row_ctrl.sv
module bank_row_ctrl
  import brc_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int T_PRE = 3,
  parameter int T_ACT = 4,
  parameter int T_CAS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_close_page,
  output logic             cmd_valid,
  output logic [1:0]       cmd_code,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             done_valid,
  output logic [1:0]       done_class
);
  st_e              state;
  cmd_e             cmd;
  cls_e             cls_now, cls_q;
  logic             accept, cmd_fire, done;
  logic             open_vld;
  logic [ROW_W-1:0] open_row, row_q;
  logic [COL_W-1:0] col_q;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      cls_q <= CLS_EMPTY;
    end else if (accept) begin
      row_q <= req_row;
      col_q <= req_col;
      cls_q <= cls_now;
    end
  end

  brc_row_tracker #(.ROW_W(ROW_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_fire  (cmd_fire),
    .cmd       (cmd),
    .cmd_row   (cmd_row),
    .probe_row (req_row),
    .open_vld  (open_vld),
    .open_row  (open_row),
    .probe_cls (cls_now)
  );

  brc_sequencer #(.T_PRE(T_PRE), .T_ACT(T_ACT), .T_CAS(T_CAS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .first_cls (cls_now),
    .close_req (req_close_page),
    .state     (state),
    .cmd_fire  (cmd_fire),
    .cmd       (cmd),
    .done      (done)
  );

  always_comb begin
    cmd_row = '0;
    cmd_col = '0;
    if (cmd_fire) begin
      if (cmd == CMD_PRE) cmd_row = open_row;
      else                cmd_row = row_q;
      if (cmd == CMD_COL) cmd_col = col_q;
    end
  end

  assign cmd_valid  = cmd_fire;
  assign cmd_code   = cmd_fire ? cmd : CMD_NOP;
  assign done_valid = done;
  assign done_class = done ? cls_q : 2'd0;

  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
  // R3
  hit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_now == CLS_HIT) |=> (cmd_valid && cmd_code == 2'd3));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: tb/tb_bank_row_ctrl.sv
module tb_bank_row_ctrl;
  localparam int TP = 3;
  localparam int TA = 4;
  localparam int TC = 2;
  localparam int NREQ = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_row = '0;
  logic [11:0] req_col = '0;
  logic        req_close_page = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [11:0] cmd_row, cmd_col;
  logic        done_valid;
  logic [1:0]  done_class;

  always #10 clk = ~clk;

  bank_row_ctrl #(.ROW_W(12), .COL_W(12), .T_PRE(TP), .T_ACT(TA), .T_CAS(TC)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_close_page(req_close_page),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .done_valid(done_valid), .done_class(done_class)
  );

  typedef struct {
    bit       rdy;
    bit       cv;
    bit [1:0] cc;
    bit [11:0] r;
    bit [11:0] c;
    bit       dv;
    bit [1:0] dc;
    string    tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   m_open = 0;
  bit [11:0] m_row = '0;

  int        rq_row[NREQ] = '{5, 5, 4095, 4095, 0, 0, 0, 1, 2};
  int        rq_col[NREQ] = '{9, 0, 4095, 1, 7, 3, 4, 2, 2};
  bit        rq_cls[NREQ] = '{0, 0, 0, 0, 1, 0, 1, 0, 0};
  int        rq_gap[NREQ] = '{0, 2, 0, 0, 1, 0, 0, 3, 0};

  function automatic exp_t blank(string t);
    exp_t e;
    e.rdy = 0; e.cv = 0; e.cc = 0; e.r = 0; e.c = 0; e.dv = 0; e.dc = 0; e.tag = t;
    return e;
  endfunction

  task automatic push_cmd(bit [1:0] code, bit [11:0] r, bit [11:0] c, int len, int cls, bit fin, string t);
    for (int i = 0; i < len; i++) begin
      exp_t e = blank(t);
      if (i == 0) begin e.cv = 1; e.cc = code; e.r = r; e.c = c; end
      if (fin && i == len - 1) begin e.dv = 1; e.dc = 2'(cls); end
      q.push_back(e);
    end
  endtask

  task automatic model_accept(bit [11:0] r, bit [11:0] c, bit cls_pg);
    int cls;
    string t;
    if (!m_open) begin cls = 1; t = "R4"; end
    else if (m_row == r) begin cls = 0; t = "R3"; end
    else begin cls = 2; t = "R5"; end
    if (cls == 2) push_cmd(2'd1, m_row, 12'd0, TP, cls, 0, t);
    if (cls != 0) push_cmd(2'd2, r, 12'd0, TA, cls, 0, t);
    push_cmd(2'd3, r, c, TC, cls, 1, t);
    if (cls_pg) begin
      push_cmd(2'd1, r, 12'd0, TP, cls, 0, "R8");
      m_open = 0;
    end else begin
      m_open = 1;
      m_row = r;
    end
  endtask

  task automatic check_one(string t, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  bit cur_idle;
  bit started = 0;

  task automatic compare();
    exp_t e;
    string t;
    if (q.size() > 0) e = q.pop_front();
    else begin e = blank(started ? "R7" : "R1"); e.rdy = 1; end
    cur_idle = e.rdy;
    t = e.tag;
    check_one(e.rdy ? t : "R2", "req_ready", int'(req_ready), int'(e.rdy));
    check_one(t, "cmd_valid (R6)", int'(cmd_valid), int'(e.cv));
    if (e.cv) begin
      check_one(t, "cmd_code (R6)", int'(cmd_code), int'(e.cc));
      check_one(t, "cmd_row (R6)", int'(cmd_row), int'(e.r));
      if (e.cc == 2'd3) check_one(t, "cmd_col (R6)", int'(cmd_col), int'(e.c));
    end
    check_one(t, "done_valid (R9)", int'(done_valid), int'(e.dv));
    if (e.dv) check_one(t, "done_class (R9)", int'(done_class), int'(e.dc));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int idx = 0;
    int gap;
    int tail = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    gap = rq_gap[0];
    while (tail < 12) begin
      @(negedge clk);
      compare();
      if (cur_idle && idx < NREQ) begin
        if (gap > 0) begin
          gap--;
          req_valid = 1'b0;
        end else begin
          req_valid = 1'b1;
          req_row = 12'(rq_row[idx]);
          req_col = 12'(rq_col[idx]);
          req_close_page = rq_cls[idx];
          model_accept(12'(rq_row[idx]), 12'(rq_col[idx]), rq_cls[idx]);
          started = 1;
          idx++;
          if (idx < NREQ) gap = rq_gap[idx];
        end
      end else if (!cur_idle && idx < NREQ && gap == 0) begin
        // R2: next request held on the pins while busy; must be ignored
        req_valid = 1'b1;
        req_row = 12'(rq_row[idx]);
        req_col = 12'(rq_col[idx]);
        req_close_page = rq_cls[idx];
      end else begin
        req_valid = 1'b0;
      end
      if (idx >= NREQ && q.size() == 0) tail++;
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule